// File: doc/BRIEF.md
# Byte-Serial Configuration Register Port

This block gives a local client read and write access to a bank of 32-bit configuration words held inside the block. Data crosses the local side eight bits at a time, so each word takes four consecutive cycles. The lowest byte always comes first.

The block also has a link-side configuration path, made of a pending flag and a direct word-write port. That path has priority over the local client. A local operation that has been accepted is parked until the link side is quiet, and only then is it carried out. For a read, an acknowledge pulse marks the first byte of returned data. For a write, the same pulse reports that the word has been stored.

The client starts an operation with a one-cycle enable pulse while the port is idle. It then waits for the acknowledge before issuing the next request.

Top module: `cfg_byte_port`

## Requirements
- R1: After reset the acknowledge is low, the read byte output is zero, and every configuration word reads back as zero.
- R2: A read-enable pulse in an idle cycle c0 with no link activity makes the acknowledge high in cycle c0+2, and the acknowledge is high for exactly one cycle.
- R3: Read data leaves least significant byte first: bits [7:0] in the acknowledge cycle, then [15:8], [23:16] and [31:24] in the next three cycles. The output is zero in every other cycle.
- R4: Write data enters least significant byte first: bits [7:0] in the cycle of the write-enable pulse, then the three higher bytes in the three following cycles. The assembled word is what later reads return.
- R5: With no link activity, a write whose enable is in cycle c0 is stored at the end of cycle c0+4 and acknowledged with a one-cycle pulse in cycle c0+5.
- R6: A local word is stored, or a read word is sampled, only in a cycle where both the link pending flag and the link write strobe are low. Every cycle of link activity delays the acknowledge by one cycle.
- R7: Write bytes are captured on schedule even while the link pending flag is high. Only the store is deferred.
- R8: If a link write and a parked local write target the same word in the same cycle, the link data is stored first. The local word is stored in the next free cycle and is the value that remains.
- R9: Address bits [1:0] are ignored, and bits [5:2] select one of the 16 words. This decode applies to both the local address and the link address.
- R10: If read enable and write enable are high in the same idle cycle, a read is performed and the write is discarded: no word changes and no second acknowledge appears.
- R11: Enables that arrive while an operation is in progress, between its request and its last data byte, are ignored.
- R12: A link write strobe stores the full 32-bit link data into the addressed word at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_rd_en | input | 1 | Local read request pulse |
| loc_wr_en | input | 1 | Local write request pulse, coincident with byte 0 |
| loc_addr | input | 12 | Local byte address; bits [1:0] ignored |
| loc_wbyte | input | 8 | Local write byte stream |
| loc_ack | output | 1 | Store done (write) or first read byte valid (read) |
| loc_rbyte | output | 8 | Local read byte stream |
| cfg_pending | input | 1 | Link-side configuration request outstanding |
| cfg_wr | input | 1 | Link-side word write strobe |
| cfg_addr | input | 12 | Link-side byte address; bits [1:0] ignored |
| cfg_wdata | input | 32 | Link-side write word |

## Verification
The assertions assume that the client issues enables only while the port is idle, or accepts that enables given while the port is busy are dropped. They also assume that the write byte stream follows its enable without gaps. The bench waits out each acknowledge and the full read byte stream before it starts the next request. It drives the link pending flag and the link strobe only in patterns whose effect on the acknowledge cycle it has computed in advance. Deliberate violations, such as a simultaneous read and write or a mid-operation enable, are issued only where the requirements define the expected outcome.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WCAP,
      ST_WAIT,
      ST_RWAIT,
      ST_RSEND
   } port_state_t;
endpackage

// File: rtl/cfg_wr_deser.sv
module cfg_wr_deser #(
   parameter int BYTE_W = 8,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [BYTE_W-1:0]        din,
   output logic [BYTE_W*NBYTES-1:0] word,
   output logic                     last
);
   localparam int WORD_W = BYTE_W * NBYTES;
   localparam int CNT_W  = $clog2(NBYTES);

   logic [CNT_W-1:0]  cnt_q;
   logic              act_q;
   logic [WORD_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         act_q   <= 1'b0;
         stage_q <= '0;
      end else if (start) begin
         stage_q[BYTE_W-1:0] <= din;
         cnt_q               <= CNT_W'(1);
         act_q               <= 1'b1;
      end else if (act_q) begin
         stage_q[int'(cnt_q)*BYTE_W +: BYTE_W] <= din;
         if (cnt_q == CNT_W'(NBYTES-1)) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign word = stage_q;
   assign last = act_q && (cnt_q == CNT_W'(NBYTES-1));

   // R4: an idle stager always restarts from byte zero
   assert_stage_rewound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> (cnt_q == '0));
endmodule

// File: rtl/cfg_rd_ser.sv
module cfg_rd_ser #(
   parameter int BYTE_W = 8,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [BYTE_W*NBYTES-1:0] word,
   output logic [BYTE_W-1:0]        dout,
   output logic                     tail
);
   localparam int WORD_W = BYTE_W * NBYTES;
   localparam int CNT_W  = $clog2(NBYTES + 1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= word;
         cnt_q <= CNT_W'(NBYTES);
      end else if (cnt_q != '0) begin
         sh_q  <= sh_q >> BYTE_W;
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign dout = sh_q[BYTE_W-1:0];
   assign tail = (cnt_q == CNT_W'(1));

   // R3: once all bytes are shifted out the output lane carries zero
   assert_drained_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (sh_q == '0));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 16,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_we,
   input  logic [IDX_W-1:0]  link_idx,
   input  logic [WORD_W-1:0] link_data,
   input  logic              loc_we,
   input  logic [IDX_W-1:0]  loc_idx,
   input  logic [WORD_W-1:0] loc_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORDS*WORD_W-1:0] flat;

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (link_we && (link_idx == IDX_W'(i)))
            word_q <= link_data;
         else if (loc_we && (loc_idx == IDX_W'(i)))
            word_q <= loc_data;
      end
      assign flat[i*WORD_W +: WORD_W] = word_q;
   end

   assign rd_data = flat[int'(rd_idx)*WORD_W +: WORD_W];

   // R8: a local store never shares a cycle with a link store
   assert_local_yields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      loc_we |-> !link_we);
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
   parameter int ADDR_W = 12,
   parameter int BYTE_W = 8,
   parameter int NBYTES = 4,
   parameter int WORDS  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     loc_rd_en,
   input  logic                     loc_wr_en,
   input  logic [ADDR_W-1:0]        loc_addr,
   input  logic [BYTE_W-1:0]        loc_wbyte,
   output logic                     loc_ack,
   output logic [BYTE_W-1:0]        loc_rbyte,
   input  logic                     cfg_pending,
   input  logic                     cfg_wr,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  logic [BYTE_W*NBYTES-1:0] cfg_wdata
);
   import cfg_port_pkg::*;

   localparam int WORD_W = BYTE_W * NBYTES;
   localparam int IDX_W  = $clog2(WORDS);
   localparam int LSB    = 2;

   if (NBYTES < 2) begin : g_bad_nbytes
      $error("cfg_byte_port: NBYTES must be at least 2");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("cfg_byte_port: WORDS must be at least 2");
   end
   if (ADDR_W < LSB + IDX_W) begin : g_bad_addr
      $error("cfg_byte_port: ADDR_W too narrow for WORDS");
   end

   port_state_t       state_q, state_d;
   logic [IDX_W-1:0]  idx_q;
   logic              ack_q, ack_d;
   logic              hold, commit, launch, rd_start, wr_start;
   logic              wr_last, rd_tail;
   logic [WORD_W-1:0] stage_word, rd_word;
   logic              unused_addr;

   assign hold        = cfg_pending | cfg_wr;
   assign unused_addr = ^{loc_addr, cfg_addr};

   always_comb begin
      state_d  = state_q;
      ack_d    = 1'b0;
      commit   = 1'b0;
      launch   = 1'b0;
      rd_start = 1'b0;
      wr_start = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (loc_rd_en) begin
               rd_start = 1'b1;
               state_d  = ST_RWAIT;
            end else if (loc_wr_en) begin
               wr_start = 1'b1;
               state_d  = ST_WCAP;
            end
         end
         ST_WCAP:  if (wr_last) state_d = ST_WAIT;
         ST_WAIT: begin
            if (!hold) begin
               commit  = 1'b1;
               ack_d   = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_RWAIT: begin
            if (!hold) begin
               launch  = 1'b1;
               ack_d   = 1'b1;
               state_d = ST_RSEND;
            end
         end
         ST_RSEND: if (rd_tail) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         ack_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ack_q   <= ack_d;
         if (rd_start || wr_start) idx_q <= loc_addr[LSB +: IDX_W];
      end
   end

   cfg_wr_deser #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_deser (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_start),
      .din   (loc_wbyte),
      .word  (stage_word),
      .last  (wr_last)
   );

   cfg_regfile #(.WORD_W(WORD_W), .WORDS(WORDS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_we   (cfg_wr),
      .link_idx  (cfg_addr[LSB +: IDX_W]),
      .link_data (cfg_wdata),
      .loc_we    (commit),
      .loc_idx   (idx_q),
      .loc_data  (stage_word),
      .rd_idx    (idx_q),
      .rd_data   (rd_word)
   );

   cfg_rd_ser #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (launch),
      .word  (rd_word),
      .dout  (loc_rbyte),
      .tail  (rd_tail)
   );

   assign loc_ack = ack_q;

   // R2: acknowledge is a single-cycle pulse
   assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      loc_ack |=> !loc_ack);

   // R6: acknowledge only follows a cycle free of link activity
   assert_ack_after_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      loc_ack |-> $past(!(cfg_pending || cfg_wr)));

   // R11: a streaming read can only finish, never switch to another operation
   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RSEND) |=> (state_q == ST_RSEND || state_q == ST_IDLE));
endmodule

// File: tb/cfg_byte_port_test.sv
module cfg_byte_port_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loc_rd_en = 1'b0;
   logic        loc_wr_en = 1'b0;
   logic [11:0] loc_addr = '0;
   logic [7:0]  loc_wbyte = '0;
   logic        loc_ack;
   logic [7:0]  loc_rbyte;
   logic        cfg_pending = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_byte_port uut (
      .clk(clk), .rst_n(rst_n),
      .loc_rd_en(loc_rd_en), .loc_wr_en(loc_wr_en), .loc_addr(loc_addr),
      .loc_wbyte(loc_wbyte), .loc_ack(loc_ack), .loc_rbyte(loc_rbyte),
      .cfg_pending(cfg_pending), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata)
   );

   function automatic logic [31:0] pat(int i);
      return {8'(i*37 + 11), 8'(195 - i), 8'(i*5), 8'(i ^ 90)};
   endfunction

   function automatic logic [11:0] waddr(int w, int low);
      return 12'((w << 2) | (low & 3));
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(logic [11:0] a, logic [31:0] d, int pend_last,
                           int link_k, logic [11:0] la, logic [31:0] ld,
                           int exp_ack, string tag);
      int ack_at = -1;
      int acks = 0;
      for (int k = 0; k <= exp_ack + 2; k++) begin
         @(negedge clk);
         if (loc_ack) begin acks++; if (ack_at < 0) ack_at = k; end
         loc_wr_en   = (k == 0);
         loc_addr    = a;
         loc_wbyte   = (k < 4) ? d[k*8 +: 8] : 8'h00;
         cfg_pending = (k <= pend_last);
         cfg_wr      = (k == link_k);
         cfg_addr    = la;
         cfg_wdata   = ld;
      end
      check(ack_at == exp_ack && acks == 1, {tag, " write ack cycle"},
            32'(ack_at), 32'(exp_ack));
   endtask

   task automatic do_read(logic [11:0] a, logic [31:0] exp, int pend_last,
                          int exp_ack, bit both, bit poke, logic [11:0] poke_a,
                          string tag);
      int ack_at = -1;
      int acks = 0;
      bit data_ok = 1'b1;
      logic [31:0] got = '0;
      for (int k = 0; k <= exp_ack + 5; k++) begin
         @(negedge clk);
         if (loc_ack) begin acks++; if (ack_at < 0) ack_at = k; end
         if (k >= exp_ack && k < exp_ack + 4) begin
            got[(k-exp_ack)*8 +: 8] = loc_rbyte;
         end else if (loc_rbyte != 8'h00) begin
            data_ok = 1'b0;
         end
         loc_rd_en   = (k == 0);
         loc_wr_en   = (k == 0 && both) || (k == 1 && poke);
         loc_addr    = (k == 0) ? a : poke_a;
         loc_wbyte   = (loc_wr_en) ? 8'hEE : 8'h00;
         cfg_pending = (k <= pend_last);
         cfg_wr      = 1'b0;
      end
      check(ack_at == exp_ack && acks == 1, {tag, " read ack cycle"},
            32'(ack_at), 32'(exp_ack));
      check(data_ok && got == exp, {tag, " read bytes"}, got, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(loc_ack == 1'b0, "R1 ack after reset", 32'(loc_ack), 32'h0);
      check(loc_rbyte == 8'h00, "R1 rbyte after reset", 32'(loc_rbyte), 32'h0);
      // R1: every word cleared
      for (int i = 0; i < 16; i++)
         do_read(waddr(i, 0), 32'h0, -1, 2, 1'b0, 1'b0, 12'h0, "R1 R2 R3");
      // R4 R5 R7 R9: write sweep with pending spanning the byte stream
      for (int i = 0; i < 16; i++)
         do_write(waddr(i, i % 4), pat(i), 3 + (i % 4), -1, 12'h0, 32'h0,
                  5 + (i % 4), "R4 R5 R7 R9");
      // R2 R3 R6 R9: read sweep with varying link hold-off
      for (int i = 0; i < 16; i++)
         do_read(waddr(i, 3 - (i % 4)), pat(i), i % 3, (i % 3) + 2,
                 1'b0, 1'b0, 12'h0, "R2 R3 R6 R9");
      // R12: direct link write, then read back
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = waddr(5, 2); cfg_wdata = 32'hDEADBEEF;
      @(negedge clk);
      cfg_wr = 1'b0;
      do_read(waddr(5, 0), 32'hDEADBEEF, -1, 2, 1'b0, 1'b0, 12'h0, "R12");
      // R8: link write to the same word in the local store cycle
      do_write(waddr(7, 0), 32'h11223344, -1, 4, waddr(7, 1), 32'h99999999,
               6, "R8 R6");
      do_read(waddr(7, 0), 32'h11223344, -1, 2, 1'b0, 1'b0, 12'h0, "R8");
      // R6 R12: link write to another word in the local store cycle
      do_write(waddr(8, 0), 32'h55667788, -1, 4, waddr(9, 0), 32'hA0B0C0D0,
               6, "R6 R12");
      do_read(waddr(8, 0), 32'h55667788, -1, 2, 1'b0, 1'b0, 12'h0, "R6");
      do_read(waddr(9, 0), 32'hA0B0C0D0, -1, 2, 1'b0, 1'b0, 12'h0, "R12");
      // R10: read and write together act as a read only
      do_read(waddr(3, 0), pat(3), -1, 2, 1'b1, 1'b0, 12'h0, "R10");
      do_read(waddr(3, 0), pat(3), -1, 2, 1'b0, 1'b0, 12'h0, "R10 unchanged");
      // R11: write enable during a parked read is dropped
      do_read(waddr(2, 0), pat(2), 2, 4, 1'b0, 1'b1, waddr(4, 0), "R11");
      do_read(waddr(4, 0), pat(4), -1, 2, 1'b0, 1'b0, 12'h0, "R11 unchanged");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule